// File: doc/BRIEF.md
# Hardware Event Status and Interrupt Latch

This block gathers asynchronous hardware events for a dual card reader into one read-only status byte and an active-low interrupt line. The events are a change of level on either card's presence contact, a supply or reset-line fault on either card, an over-temperature flag, a supply supervisor alarm, and a level change on an auxiliary interrupt input. Every raw event input is brought into the clock domain through a two-flop synchronizer before it is used.

A host reads the byte from `stat_o` and pulses `stat_rd_i` for one cycle as it does so. That edge clears the latched bits, except where a condition is still active. The supervisor bit comes out of reset set. It stays set until a read arrives after the alarm pulse has ended. Its share of the interrupt is released as soon as the alarm pulse ends.

Whenever a latch that forces deactivation changes from clear to set, `emerg_stop_o` gives a one-cycle pulse. The activation sequencer uses this pulse to drop its start bit. Every latch forces deactivation except the auxiliary one.

Top module: `hw_event_status`

## Requirements
- R1: Status byte fields by bit position: bit 0 over-temperature, bit 1 auxiliary change, bit 2 card-1 presence change, bit 3 card-2 presence change, bit 4 supervisor, bit 5 card-1 protection, bit 6 card-2 protection. Bit 7 always reads 0.
- R2: A level change on `pres_i[0]` or `pres_i[1]`, rising or falling, sets bit 2 or bit 3 respectively. The bit is visible after the third rising clock edge that follows the input change.
- R3: Bit 5 (bit 6) is set while `vcc_fault_i[0]` or `rst_fault_i[0]` (respectively `[1]`) is high. It stays set after the fault goes away, until the next read.
- R4: Bit 0 is set while `overtemp_i` is high and stays latched until a read made after the flag has dropped.
- R5: `int_n_o` is low when any of bits 0, 2, 3, 5 or 6 is set. It is also low when bit 1 is set and `aux_en_i` is 1, and when bit 4 is set while the synchronized alarm is high. Otherwise it is high.
- R6: A cycle with `stat_rd_i` = 1 clears the latched bits at the next edge. When `aux_en_i` = 0, bit 1 is left untouched by the read.
- R7: A read while the synchronized alarm is high does not clear bit 4. A read after the alarm has ended clears it. The interrupt from bit 4 is released when the synchronized alarm falls.
- R8: An event whose set condition falls on the same edge as a clearing read stays latched.
- R9: `emerg_stop_o` is high for exactly one cycle, in the same cycle that any of bits 0, 2, 3, 4, 5 or 6 turns from 0 to 1. An auxiliary event alone never produces it.
- R10: Input levels present during and right after reset do not produce presence or auxiliary change bits.
- R11: During reset `stat_o` is 8'h10, `int_n_o` is 0 and `emerg_stop_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pres_i | input | 2 | Raw presence contacts, index 0 = card 1 |
| vcc_fault_i | input | 2 | Raw card supply fault flags |
| rst_fault_i | input | 2 | Raw card reset-line fault flags |
| alarm_i | input | 1 | Raw supervisor alarm pulse active |
| overtemp_i | input | 1 | Raw over-temperature flag |
| aux_irq_i | input | 1 | Raw auxiliary interrupt level |
| aux_en_i | input | 1 | 1 = auxiliary latch drives interrupt and is cleared by reads |
| stat_rd_i | input | 1 | One-cycle read strobe of the status byte |
| stat_o | output | 8 | Status byte |
| int_n_o | output | 1 | Active-low interrupt |
| emerg_stop_o | output | 1 | One-cycle emergency deactivation pulse |

## Verification
A raw input change passes two synchronizer flops and the latch register. Each latched bit, the interrupt level that depends on it, and the emergency pulse therefore appear after the third rising edge following the change. A read strobe acts on the first edge after it. The bench changes inputs on falling edges and waits four rising edges before sampling mid-cycle, so every settled value is seen late enough. The same-edge read case and the pulse-width case count edges exactly, and the emergency pulse is sampled in the cycle the latch appears and in the cycle after it.

// File: rtl/hwstat_pkg.sv
package hwstat_pkg;
  // Status byte layout (host-decoded, positions are fixed)
  localparam int STAT_W  = 8;
  localparam int B_OT    = 0;
  localparam int B_AUX   = 1;
  localparam int B_PRES1 = 2;
  localparam int B_PRES2 = 3;
  localparam int B_SUP   = 4;
  localparam int B_PROT1 = 5;
  localparam int B_PROT2 = 6;

  localparam logic [STAT_W-1:0] STAT_RST   = 8'h10;
  // latches that force deactivation: all but the auxiliary one
  localparam logic [STAT_W-1:0] DEACT_MASK = 8'h7D;
  // latches that always pull the interrupt
  localparam logic [STAT_W-1:0] HARD_IRQ   = 8'h6D;

  // Raw event bundle
  localparam int RAW_W   = 9;
  localparam int I_PRES  = 0;
  localparam int I_VCCF  = 2;
  localparam int I_RSTF  = 4;
  localparam int I_ALARM = 6;
  localparam int I_OT    = 7;
  localparam int I_AUX   = 8;
  // alarm is taken as active while in reset
  localparam logic [RAW_W-1:0] RAW_RST = 9'h040;
endpackage

// File: rtl/hwstat_sync.sv
module hwstat_sync #(
  parameter int               W       = 9,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  localparam int            CW        = $clog2(STAGES + 2);
  localparam logic [CW-1:0] READY_CNT = CW'(STAGES + 1);

  logic [STAGES-1:0][W-1:0] stage_q, stage_d;
  logic [W-1:0]             prev_q;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic                     ready;

  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      if (s == 0) stage_d[s] = raw_i;
      else        stage_d[s] = stage_q[s-1];
    end
  end

  assign ready = (cnt_q == READY_CNT);
  assign cnt_d = ready ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= stage_q[STAGES-1];
      cnt_q   <= cnt_d;
    end
  end

  assign lvl_o = stage_q[STAGES-1];
  // R10: no change reported until the chain and the history hold real samples
  assign chg_o = ready ? (lvl_o ^ prev_q) : '0;

  // R10: the warm-up counter never passes the ready value
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/hwstat_latch_bank.sv
module hwstat_latch_bank #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q, bit_d;

    // R8: a set condition wins over a clear on the same edge
    always_comb bit_d = (bit_q & ~clr_i[i]) | set_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= RST_VAL[i];
      else        bit_q <= bit_d;
    end

    assign q_o[i] = bit_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/hwstat_irq.sv
module hwstat_irq
  import hwstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_q_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              aux_en_i,
  input  logic              alarm_lvl_i,
  output logic              int_n_o,
  output logic              emerg_o
);
  logic [STAT_W-1:0] irq_src;
  logic              emerg_q, emerg_d;

  // R5: interrupt sources, auxiliary gated by enable, supervisor by alarm
  always_comb begin
    irq_src          = stat_q_i & HARD_IRQ;
    irq_src[B_AUX]   = stat_q_i[B_AUX] & aux_en_i;
    irq_src[B_SUP]   = stat_q_i[B_SUP] & alarm_lvl_i;
  end
  assign int_n_o = ~(|irq_src);

  // R9: a deactivating latch that is clear now and set next edge
  assign emerg_d = |(DEACT_MASK & set_i & ~stat_q_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) emerg_q <= 1'b0;
    else        emerg_q <= emerg_d;
  end
  assign emerg_o = emerg_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_deact
    if (DEACT_MASK[i]) begin : g_chk
      a_r9_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q_i[i]) |-> emerg_o);
    end
  end

  a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_o |-> (|(stat_q_i & DEACT_MASK)));
endmodule

// File: rtl/hw_event_status.sv
module hw_event_status
  import hwstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pres_i,
  input  logic [1:0]  vcc_fault_i,
  input  logic [1:0]  rst_fault_i,
  input  logic        alarm_i,
  input  logic        overtemp_i,
  input  logic        aux_irq_i,
  input  logic        aux_en_i,
  input  logic        stat_rd_i,
  output logic [7:0]  stat_o,
  output logic        int_n_o,
  output logic        emerg_stop_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [RAW_W-1:0]  raw, lvl, chg;
  logic [STAT_W-1:0] set_v, clr_v, stat_q;
  logic              alarm_lvl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    raw                  = '0;
    raw[I_PRES +: 2]     = pres_i;
    raw[I_VCCF +: 2]     = vcc_fault_i;
    raw[I_RSTF +: 2]     = rst_fault_i;
    raw[I_ALARM]         = alarm_i;
    raw[I_OT]            = overtemp_i;
    raw[I_AUX]           = aux_irq_i;
  end

  hwstat_sync #(
    .W       (RAW_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (RAW_RST)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .raw_i (raw),
    .lvl_o (lvl),
    .chg_o (chg)
  );

  assign alarm_lvl = lvl[I_ALARM];

  // set conditions: edges for presence and auxiliary, levels otherwise
  always_comb begin
    set_v          = '0;
    set_v[B_OT]    = lvl[I_OT];
    set_v[B_AUX]   = chg[I_AUX];
    set_v[B_PRES1] = chg[I_PRES];
    set_v[B_PRES2] = chg[I_PRES+1];
    set_v[B_SUP]   = alarm_lvl;
    set_v[B_PROT1] = lvl[I_VCCF]   | lvl[I_RSTF];
    set_v[B_PROT2] = lvl[I_VCCF+1] | lvl[I_RSTF+1];
  end

  // clear enables for a read strobe
  always_comb begin
    clr_v = '0;
    if (stat_rd_i) begin
      clr_v          = DEACT_MASK;
      clr_v[B_SUP]   = ~alarm_lvl;
      clr_v[B_AUX]   = aux_en_i;
    end
  end

  hwstat_latch_bank #(
    .W       (STAT_W),
    .RST_VAL (STAT_RST)
  ) bank_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (stat_q)
  );

  hwstat_irq irq_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .stat_q_i    (stat_q),
    .set_i       (set_v),
    .aux_en_i    (aux_en_i),
    .alarm_lvl_i (alarm_lvl),
    .int_n_o     (int_n_o),
    .emerg_o     (emerg_stop_o)
  );

  assign stat_o = stat_q;

  a_r7_sup_held_in_alarm: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stat_q[B_SUP] && alarm_lvl) |=> stat_q[B_SUP]);
  a_r2_pres1_latch: assert property (@(posedge clk) disable iff (!rst_sync_q)
    chg[I_PRES] |=> stat_q[B_PRES2-1]);
  a_r2_pres2_latch: assert property (@(posedge clk) disable iff (!rst_sync_q)
    chg[I_PRES+1] |=> stat_q[B_PRES2]);
  a_r6_aux_kept_when_masked: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stat_q[B_AUX] && !aux_en_i) |=> stat_q[B_AUX]);
endmodule

// File: tb/hw_event_status_tb.sv
`timescale 1ns/1ps
module hw_event_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pres, vccf, rstf;
  logic       alarm, ot, aux, aux_en, rd;
  logic [7:0] stat;
  logic       int_n, emerg;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  hw_event_status dut_i (
    .clk (clk), .rst_n (rst_n), .pres_i (pres), .vcc_fault_i (vccf),
    .rst_fault_i (rstf), .alarm_i (alarm), .overtemp_i (ot),
    .aux_irq_i (aux), .aux_en_i (aux_en), .stat_rd_i (rd),
    .stat_o (stat), .int_n_o (int_n), .emerg_stop_o (emerg)
  );

  // inputs {pres[1:0], vccf[1:0], rstf[1:0], alarm, ot, aux, aux_en, rd},
  // settled stat, settled int_n, stat after read/idle, int_n after
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {11'b00_00_00_1_0_0_1_1, 8'h10, 1'b0, 8'h10, 1'b0},  // R7 read in alarm
    {11'b00_00_00_0_0_0_1_1, 8'h10, 1'b1, 8'h00, 1'b1},  // R7 release, clear
    {11'b01_00_00_0_0_0_1_1, 8'h04, 1'b0, 8'h00, 1'b1},  // R2 rise card 1
    {11'b10_00_00_0_0_0_1_1, 8'h0C, 1'b0, 8'h00, 1'b1},  // R2 both, fall on 1
    {11'b10_01_00_0_0_0_1_1, 8'h20, 1'b0, 8'h20, 1'b0},  // R3 supply fault held
    {11'b10_00_00_0_0_0_1_1, 8'h20, 1'b0, 8'h00, 1'b1},  // R3 cleared after fault
    {11'b10_00_10_0_0_0_1_0, 8'h40, 1'b0, 8'h40, 1'b0},  // R3 reset-line card 2
    {11'b10_00_00_0_0_0_1_1, 8'h40, 1'b0, 8'h00, 1'b1},  // R6
    {11'b10_00_00_0_1_0_1_1, 8'h01, 1'b0, 8'h01, 1'b0},  // R4 held while hot
    {11'b10_00_00_0_0_0_1_1, 8'h01, 1'b0, 8'h00, 1'b1},  // R4
    {11'b10_00_00_0_0_1_0_1, 8'h02, 1'b1, 8'h02, 1'b1},  // R5 R6 masked aux
    {11'b10_00_00_0_0_1_1_1, 8'h02, 1'b0, 8'h00, 1'b1},  // R5 R6 enabled aux
    {11'b10_00_00_0_0_0_1_0, 8'h02, 1'b0, 8'h02, 1'b0},  // R1 aux falling
    {11'b10_00_00_0_0_0_1_1, 8'h02, 1'b0, 8'h00, 1'b1},  // R6
    {11'b10_00_00_1_0_0_1_1, 8'h10, 1'b0, 8'h10, 1'b0},  // R7 alarm again
    {11'b10_00_00_0_0_0_1_0, 8'h10, 1'b1, 8'h10, 1'b1},  // R7 int released
    {11'b10_00_00_0_0_0_1_1, 8'h10, 1'b1, 8'h00, 1'b1}   // R7 clear after alarm
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int pulses;
    rst_n = 1'b0; pres = '0; vccf = '0; rstf = '0;
    alarm = 1'b1; ot = 1'b0; aux = 1'b0; aux_en = 1'b1; rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 stat", stat, 8'h10);
    check("R11 int_n", {7'b0, int_n}, 8'h00);
    check("R11 emerg", {7'b0, emerg}, 8'h00);
    check("R1 bit7", {7'b0, stat[7]}, 8'h00);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {pres, vccf, rstf, alarm, ot, aux, aux_en, rd} = VEC[v][28:18];
      rd = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d stat", v), stat, VEC[v][17:10]);
      check($sformatf("vec%0d int_n R5", v), {7'b0, int_n}, {7'b0, VEC[v][9]});
      rd = VEC[v][18];
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      check($sformatf("vec%0d post stat R6", v), stat, VEC[v][8:1]);
      check($sformatf("vec%0d post int_n R5", v), {7'b0, int_n}, {7'b0, VEC[v][0]});
    end

    // R8: card-1 presence event lands on the same edge as a read
    pres[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    check("R8 kept", stat, 8'h04);
    check("R9 pulse on set", {7'b0, emerg}, 8'h01);
    @(negedge clk);
    check("R9 pulse one cycle", {7'b0, emerg}, 8'h00);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check("R6 clear", stat, 8'h00);

    // R9: exactly one pulse for a card-2 presence change
    pulses = 0;
    pres[1] = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (emerg) pulses++;
    end
    check("R9 pulse count", 8'(pulses), 8'h01);
    check("R2 fall card 2", stat, 8'h08);
    rd = 1'b1; @(negedge clk); rd = 1'b0;

    // R9: auxiliary change gives no pulse
    pulses = 0;
    aux = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (emerg) pulses++;
    end
    check("R9 aux no pulse", 8'(pulses), 8'h00);
    check("R1 aux bit", stat, 8'h02);
    rd = 1'b1; @(negedge clk); rd = 1'b0;

    // R10 / R11: reset with active input levels
    rst_n = 1'b0; pres = 2'b11; aux = 1'b1; alarm = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 stat again", stat, 8'h10);
    check("R11 emerg again", {7'b0, emerg}, 8'h00);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 no spurious edges", stat, 8'h10);
    alarm = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 int released", {7'b0, int_n}, 8'h01);

    done = 1'b1;
    summary();
  end
endmodule